// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Register

This block holds the two 32-bit command words that software uses to send an inter-processor interrupt from a local interrupt controller. The high word holds the destination. A write to the low word holds the vector and the delivery attributes, and that write also starts the send. At that moment the block builds an outbound message from the stored destination and the freshly written low-word fields. It then offers the message on a valid/ready port.

While a message is waiting to be accepted, a delivery-status bit in the low word reads as 1. Any further low-word write is dropped until the port accepts the message. Software must therefore write the destination first and the low word last. The two-bit destination shorthand is decoded and travels with the message as a destination type. Receivers interpret self and broadcast delivery.

Top module: `ipi_cmd_regs`

## Requirements
- R1: After synchronous reset, msg_valid is 0 and both command words read back as 0.
- R2: A write to the high-word address stores bits 31:24 as the destination. Reading the high word returns those bits, with bits 23:0 reading as 0.
- R3: A low-word write accepted while idle stores vector (bits 7:0), delivery mode (10:8), destination mode (11), level (14), trigger mode (15) and shorthand (19:18). On the next read, the low word shows these fields with the delivery-status bit 12 at 1. All other bits read as 0.
- R4: After an accepted low-word write, msg_valid is 1 from the next clock edge. The message carries the stored destination and the newly written low-word fields.
- R5: While msg_valid is 1 and msg_ready is 0, msg_valid stays 1 and every message field stays unchanged.
- R6: At a clock edge where msg_valid and msg_ready are both 1, msg_valid and the delivery-status bit both clear.
- R7: A low-word write while the delivery-status bit is 1 is discarded, including a write in the same cycle as the accepting handshake. The low word and the message keep their previous values.
- R8: Bit 12 of the write data has no effect. An idle low-word write with bit 12 set sends normally, and bit 12 reads as 0 once the message is accepted.
- R9: msg_target equals the shorthand code: 0 means use the destination field, 1 means self, 2 means all including self, and 3 means all excluding self.
- R10: A high-word write while a message is pending updates the stored destination but not msg_dest of the pending message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| msg_valid | output | 1 | Message offered on the outbound port |
| msg_ready | input | 1 | Outbound port accepts the message |
| msg_dest | output | 8 | Destination from the high word |
| msg_vector | output | 8 | Interrupt vector |
| msg_dmode | output | 3 | Delivery mode |
| msg_destmode | output | 1 | Destination mode |
| msg_level | output | 1 | Level bit |
| msg_trig | output | 1 | Trigger mode |
| msg_target | output | 2 | Decoded destination type |

## Verification
The hardest case to reach from the ports is a low-word write that lands in the same clock cycle as the accepting handshake. The delivery-status bit is still set when that write is sampled, so the write must be lost, even though the port is free one cycle later. The bench reaches this case by raising msg_ready and the write strobe on the same falling edge. It then checks that the message is gone and that the low word still shows the old command. Writes to the high word during a pending send are also mixed in, to show that the in-flight destination is frozen.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    typedef enum logic [1:0] {
        TGT_FIELD    = 2'd0,
        TGT_SELF     = 2'd1,
        TGT_ALL_INCL = 2'd2,
        TGT_ALL_EXCL = 2'd3
    } ipi_target_e;

    // Stored fields of the low command word (busy flag is kept apart)
    typedef struct packed {
        logic [1:0] shorthand;
        logic       trig;
        logic       level;
        logic       dest_logical;
        logic [2:0] dmode;
        logic [7:0] vector;
    } ipi_low_t;

    typedef struct packed {
        logic [7:0] dest;
        ipi_low_t   low;
    } ipi_msg_t;

    localparam int VEC_LSB   = 0;
    localparam int DMODE_LSB = 8;
    localparam int DLOG_BIT  = 11;
    localparam int BUSY_BIT  = 12;
    localparam int LEVEL_BIT = 14;
    localparam int TRIG_BIT  = 15;
    localparam int SH_LSB    = 18;
    localparam int DEST_LSB  = 24;

    function automatic ipi_low_t unpack_low(input logic [31:0] w);
        ipi_low_t r;
        r.vector       = w[VEC_LSB +: 8];
        r.dmode        = w[DMODE_LSB +: 3];
        r.dest_logical = w[DLOG_BIT];
        r.level        = w[LEVEL_BIT];
        r.trig         = w[TRIG_BIT];
        r.shorthand    = w[SH_LSB +: 2];
        return r;
    endfunction

    function automatic logic [31:0] pack_low(input ipi_low_t l, input logic busy);
        logic [31:0] w;
        w                  = '0;
        w[VEC_LSB +: 8]    = l.vector;
        w[DMODE_LSB +: 3]  = l.dmode;
        w[DLOG_BIT]        = l.dest_logical;
        w[BUSY_BIT]        = busy;
        w[LEVEL_BIT]       = l.level;
        w[TRIG_BIT]        = l.trig;
        w[SH_LSB +: 2]     = l.shorthand;
        return w;
    endfunction

endpackage

// File: rtl/ipi_cmd_store.sv
module ipi_cmd_store
    import ipi_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_low,
    input  logic        wr_high,
    input  logic [31:0] wdata,
    input  logic        accept,
    output ipi_low_t    low_q,
    output logic [7:0]  dest_q,
    output logic        busy,
    output logic        start
);
    assign start = wr_low && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q  <= '0;
            dest_q <= '0;
            busy   <= 1'b0;
        end else begin
            if (wr_high)
                dest_q <= wdata[DEST_LSB +: 8];
            if (start) begin
                low_q <= unpack_low(wdata);
                busy  <= 1'b1;
            end else if (accept) begin
                busy  <= 1'b0;
            end
        end
    end

    // R7: a low write while busy leaves the stored command untouched
    p_no_overwrite_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_low) |=> $stable(low_q) && (busy || $past(accept)));

    // R6: busy only drops through an accepted handshake
    p_busy_clear_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(accept));
endmodule

// File: rtl/ipi_msg_launch.sv
module ipi_msg_launch
    import ipi_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  ipi_low_t    low_new,
    input  logic [7:0]  dest,
    input  logic        msg_ready,
    output logic        msg_valid,
    output ipi_msg_t    msg,
    output logic        accept
);
    assign accept = msg_valid && msg_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            msg       <= '0;
        end else if (start) begin
            msg_valid <= 1'b1;
            msg.dest  <= dest;
            msg.low   <= low_new;
        end else if (accept) begin
            msg_valid <= 1'b0;
        end
    end

    // R5: held offer stays stable until taken
    p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> msg_valid && $stable(msg));

    // R6: the handshake withdraws the offer
    p_drop_on_accept_r6: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_ready) |=> !msg_valid);
endmodule

// File: rtl/ipi_short_decode.sv
module ipi_short_decode
    import ipi_pkg::*;
(
    input  logic [1:0]  shorthand,
    output ipi_target_e target
);
    always_comb begin
        case (shorthand)
            2'd1:    target = TGT_SELF;
            2'd2:    target = TGT_ALL_INCL;
            2'd3:    target = TGT_ALL_EXCL;
            default: target = TGT_FIELD;
        endcase
    end
endmodule

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs
    import ipi_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] LOW_ADDR  = 4'h0,
    parameter logic [ADDR_W-1:0] HIGH_ADDR = 4'h4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [7:0]        msg_dest,
    output logic [7:0]        msg_vector,
    output logic [2:0]        msg_dmode,
    output logic              msg_destmode,
    output logic              msg_level,
    output logic              msg_trig,
    output logic [1:0]        msg_target
);
    logic        wr_low, wr_high, busy, start, accept;
    ipi_low_t    low_q;
    logic [7:0]  dest_q;
    ipi_msg_t    msg;
    ipi_target_e target;

    assign wr_low  = bus_wr && (bus_addr == LOW_ADDR);
    assign wr_high = bus_wr && (bus_addr == HIGH_ADDR);

    ipi_cmd_store u_store (
        .clk(clk), .rst(rst), .wr_low(wr_low), .wr_high(wr_high),
        .wdata(bus_wdata), .accept(accept), .low_q(low_q),
        .dest_q(dest_q), .busy(busy), .start(start)
    );

    ipi_msg_launch u_launch (
        .clk(clk), .rst(rst), .start(start), .low_new(unpack_low(bus_wdata)),
        .dest(dest_q), .msg_ready(msg_ready), .msg_valid(msg_valid),
        .msg(msg), .accept(accept)
    );

    ipi_short_decode u_dec (.shorthand(msg.low.shorthand), .target(target));

    always_comb begin
        if (bus_addr == LOW_ADDR)
            bus_rdata = pack_low(low_q, busy);
        else if (bus_addr == HIGH_ADDR)
            bus_rdata = {dest_q, 24'h0};
        else
            bus_rdata = '0;
    end

    assign msg_dest     = msg.dest;
    assign msg_vector   = msg.low.vector;
    assign msg_dmode    = msg.low.dmode;
    assign msg_destmode = msg.low.dest_logical;
    assign msg_level    = msg.low.level;
    assign msg_trig     = msg.low.trig;
    assign msg_target   = target;

    // R6: status bit and outbound offer move together
    p_busy_is_valid_r6: assert property (@(posedge clk) disable iff (rst)
        busy == msg_valid);

    // R4: an accepted low write raises the offer on the next edge
    p_launch_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_low && !busy) |=> msg_valid && (msg_vector == $past(bus_wdata[7:0])));

    // R10: destination of a pending message is frozen
    p_dest_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && wr_high && !msg_ready) |=> $stable(msg_dest));
endmodule

// File: tb/ipi_cmd_regs_test.sv
module ipi_cmd_regs_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        msg_valid, msg_ready = 1'b0;
    logic [7:0]  msg_dest, msg_vector;
    logic [2:0]  msg_dmode;
    logic        msg_destmode, msg_level, msg_trig;
    logic [1:0]  msg_target;

    int checks = 0;
    int errors = 0;

    localparam logic [3:0] A_LOW  = 4'h0;
    localparam logic [3:0] A_HIGH = 4'h4;

    always #2.5 clk = ~clk;

    ipi_cmd_regs uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic handshake();
        @(negedge clk);
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 msg_valid", {31'b0, msg_valid}, 32'h0);
        rd(A_LOW, d);  chk("R1 low", d, 32'h0);
        rd(A_HIGH, d); chk("R1 high", d, 32'h0);
    endtask

    task automatic t_high();
        logic [31:0] d;
        wr(A_HIGH, 32'hA5FF_FFFF);
        rd(A_HIGH, d); chk("R2 high readback", d, 32'hA500_0000);
    endtask

    task automatic t_send_and_hold();
        logic [31:0] d;
        wr(A_LOW, 32'h0000_4D31);
        rd(A_LOW, d); chk("R3 low readback busy", d, 32'h0000_5D31);
        chk("R4 valid", {31'b0, msg_valid}, 32'h1);
        chk("R4 dest", {24'b0, msg_dest}, 32'hA5);
        chk("R4 fields", {16'b0, msg_vector, 1'b0, msg_dmode, msg_destmode, msg_level, msg_trig, 1'b0},
            {16'b0, 8'h31, 1'b0, 3'd5, 1'b1, 1'b1, 1'b0, 1'b0});
        chk("R9 target field", {30'b0, msg_target}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R5 still valid", {31'b0, msg_valid}, 32'h1);
        chk("R5 vector held", {24'b0, msg_vector}, 32'h31);
        wr(A_HIGH, 32'h1100_0000);
        rd(A_HIGH, d); chk("R10 high updated", d, 32'h1100_0000);
        chk("R10 msg_dest frozen", {24'b0, msg_dest}, 32'hA5);
        wr(A_LOW, 32'h0000_00FF);
        rd(A_LOW, d); chk("R7 low kept", d, 32'h0000_5D31);
        chk("R7 msg vector kept", {24'b0, msg_vector}, 32'h31);
        handshake();
        chk("R6 valid cleared", {31'b0, msg_valid}, 32'h0);
        rd(A_LOW, d); chk("R6 busy cleared", d, 32'h0000_4D31);
    endtask

    task automatic t_shorthands();
        logic [31:0] d;
        for (int s = 0; s < 4; s++) begin
            wr(A_LOW, (32'(s) << 18) | 32'h0000_9020);
            rd(A_LOW, d); chk("R8 bit12 write sends", d, (32'(s) << 18) | 32'h0000_9020);
            chk("R9 target", {30'b0, msg_target}, 32'(s));
            chk("R4 dest from high", {24'b0, msg_dest}, 32'h11);
            chk("R4 trig", {31'b0, msg_trig}, 32'h1);
            handshake();
            rd(A_LOW, d); chk("R8 bit12 clear after accept", d, (32'(s) << 18) | 32'h0000_8020);
        end
    endtask

    task automatic t_write_at_accept();
        logic [31:0] d;
        wr(A_LOW, 32'h0000_0142);
        @(negedge clk);
        msg_ready = 1'b1;
        bus_addr = A_LOW; bus_wr = 1'b1; bus_wdata = 32'h0000_0777;
        @(negedge clk);
        msg_ready = 1'b0; bus_wr = 1'b0;
        chk("R7 no relaunch at accept", {31'b0, msg_valid}, 32'h0);
        rd(A_LOW, d); chk("R7 low kept at accept", d, 32'h0000_0142);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_high();
        t_send_and_hold();
        t_shorthands();
        t_write_at_accept();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule